// File: doc/BRIEF.md
# Audio Port Routing Crossbar

This block connects one physical serial audio port to any one of several cluster engines. Each cluster delivers a bit clock, a frame sync and two transmit serializer lanes (A and B). Software picks the cluster that supplies the port's clocks and, independently, the cluster and lane that supply its serial data. The port's outputs are then gated by per-output enable bits. Every cluster signal is treated as a level sampled on the system clock. All outputs are registered, so they follow the selected source with one clock of latency.

The port has three write-only configuration words: an enable word, a clock-select word and a data-select word. The clock source is written as cluster index plus one, and zero means no source. The data-select word has one two-bit field per cluster. When more than one field is nonzero, the lowest-numbered cluster wins and a conflict flag is raised. A new selection written while the outputs it steers are running is held back until the next rising edge of the active frame sync, so a frame is never cut short. When the outputs are idle, a new selection takes effect at once. Disabled outputs are driven low.

Top module: `audio_port_xbar`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the outputs port_bclk, port_fsync, port_sdata and port_conflict are all low. Reset also clears all enables and selections.
- R2: Word 0 is the enable word. When its bit 1 is set, port_bclk equals the bit clock of the cluster named by the active clock select, one cycle late. When bit 1 is clear, port_bclk is low.
- R3: When bit 2 of word 0 is set, port_fsync equals the frame sync of the cluster named by the active clock select, one cycle late. When bit 2 is clear, port_fsync is low.
- R4: When bit 3 of word 0 is set, port_sdata carries the winning cluster's lane, one cycle late. The field for cluster c sits at bits 2c+1:2c of word 2. Field value 1 selects lane A, value 2 selects lane B, and value 3 selects lane A. When bit 3 is clear, port_sdata is low.
- R5: The clock select is bits 11:8 of word 1 and names cluster index plus one. A value of 0, or a value above the cluster count, drives port_bclk and port_fsync low.
- R6: When more than one data-select field is nonzero, the lowest-numbered busy cluster supplies the data. In that case port_conflict is high one cycle later; otherwise it is low.
- R7: When every data-select field is zero, port_sdata is low even with bit 3 set.
- R8: A clock select written while bit 1 or bit 2 is set is held back, as is a data select written while bit 3 is set. The held value becomes active at the next rising edge of the active source's frame sync.
- R9: When the relevant enable is clear, or the active clock select names no cluster, a newly written selection becomes active in the write cycle itself.
- R10: Writing 0 to word 0 and then to word 2 shuts the port down: all data and clock outputs are low from the next cycle on, and the conflict flag is clear.
- R11: A write to address 3 has no effect on any output.
- R12: Any cluster from 0 to the cluster count minus one can be routed to the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Word address: 0 enable, 1 clock select, 2 data select |
| cfg_wdata | input | DW | Write data |
| clu_bclk | input | NCLUST | Bit clock of each cluster |
| clu_fsync | input | NCLUST | Frame sync of each cluster |
| clu_txa | input | NCLUST | Serializer lane A of each cluster |
| clu_txb | input | NCLUST | Serializer lane B of each cluster |
| port_bclk | output | 1 | Port bit clock |
| port_fsync | output | 1 | Port frame sync |
| port_sdata | output | 1 | Port serial data |
| port_conflict | output | 1 | More than one data source is selected |

## Verification
Each cluster's bit clock runs at a different rate, its frame sync has a different period, and its lanes carry independent random bits, so a wrong source index or wrong lane shows up as a mismatch within a few cycles. The clock source is walked through all six clusters and then through the out-of-range codes 0 and 7. Each cluster's field is set to lane A and then to lane B, which separates the lane decode from the cluster decode. Several fields are then made busy at once to expose the priority order and the conflict flag. Writes are made both while the outputs run and while they are idle, which shows the difference between a change held back until a frame boundary and a change applied at once. Shutdown and a write to the unused address close the run.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Bit positions the port decodes from its configuration words
    localparam int EN_BCLK_BIT = 1;
    localparam int EN_FS_BIT   = 2;
    localparam int EN_DAT_BIT  = 3;
    localparam int CSEL_LSB    = 8;
    localparam int SEL_W       = 4;

    typedef enum logic [1:0] {
        ADDR_ENABLE = 2'd0,
        ADDR_CLKSEL = 2'd1,
        ADDR_DATSEL = 2'd2,
        ADDR_SPARE  = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        logic dat;
        logic fs;
        logic bclk;
    } port_en_t;

    typedef struct packed {
        logic bclk;
        logic fs;
        logic dat;
        logic conflict;
    } port_out_t;

    function automatic logic sel_in_range(logic [SEL_W-1:0] s, int n);
        return (s != '0) && (int'(s) <= n);
    endfunction

endpackage

// File: rtl/xbar_cfg_stage.sv
module xbar_cfg_stage
    import xbar_pkg::*;
#(
    parameter int NCLUST = 6,
    parameter int DW     = 16,
    localparam int DSW   = 2 * NCLUST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             src_valid,
    input  logic             boundary,
    output port_en_t         en_q,
    output logic [SEL_W-1:0] csel_q,
    output logic [DSW-1:0]   dsel_q
);

    logic [SEL_W-1:0] csel_sh_q, csel_sh_d, csel_d;
    logic [DSW-1:0]   dsel_sh_q, dsel_sh_d, dsel_d;
    port_en_t         en_d;
    logic             apply_clk, apply_dat;
    logic             unused_wdata_bits;

    assign unused_wdata_bits = ^wr_data;

    always_comb begin
        en_d      = en_q;
        csel_sh_d = csel_sh_q;
        dsel_sh_d = dsel_sh_q;
        if (wr_en) begin
            unique case (cfg_addr_e'(wr_addr))
                ADDR_ENABLE: begin
                    en_d.bclk = wr_data[EN_BCLK_BIT];
                    en_d.fs   = wr_data[EN_FS_BIT];
                    en_d.dat  = wr_data[EN_DAT_BIT];
                end
                ADDR_CLKSEL: csel_sh_d = wr_data[CSEL_LSB +: SEL_W];
                ADDR_DATSEL: dsel_sh_d = wr_data[DSW-1:0];
                default: ;
            endcase
        end
        // a running output only takes a new source on a frame boundary
        apply_clk = !(en_q.bclk || en_q.fs) || !src_valid || boundary;
        apply_dat = !en_q.dat || !src_valid || boundary;
        csel_d    = apply_clk ? csel_sh_d : csel_q;
        dsel_d    = apply_dat ? dsel_sh_d : dsel_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            csel_sh_q <= '0;
            dsel_sh_q <= '0;
            csel_q    <= '0;
            dsel_q    <= '0;
        end else begin
            en_q      <= en_d;
            csel_sh_q <= csel_sh_d;
            dsel_sh_q <= dsel_sh_d;
            csel_q    <= csel_d;
            dsel_q    <= dsel_d;
        end
    end

endmodule

// File: rtl/xbar_clk_route.sv
module xbar_clk_route
    import xbar_pkg::*;
#(
    parameter int NCLUST = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  csel,
    input  logic [NCLUST-1:0] bclk_in,
    input  logic [NCLUST-1:0] fsync_in,
    output logic              bclk_sel,
    output logic              fs_sel,
    output logic              src_valid,
    output logic              boundary
);

    logic fs_prev_q;

    assign src_valid = sel_in_range(csel, NCLUST);

    always_comb begin
        bclk_sel = 1'b0;
        fs_sel   = 1'b0;
        for (int i = 0; i < NCLUST; i++) begin
            if (csel == SEL_W'(i + 1)) begin
                bclk_sel = bclk_in[i];
                fs_sel   = fsync_in[i];
            end
        end
    end

    assign boundary = fs_sel && !fs_prev_q;

    always_ff @(posedge clk) begin
        if (rst) fs_prev_q <= 1'b0;
        else     fs_prev_q <= fs_sel;
    end

endmodule

// File: rtl/xbar_lane_pick.sv
module xbar_lane_pick #(
    parameter int NCLUST = 6,
    localparam int DSW   = 2 * NCLUST,
    localparam int CW    = $clog2(NCLUST + 1) + 1
) (
    input  logic [DSW-1:0]    dsel,
    input  logic [NCLUST-1:0] lane_a,
    input  logic [NCLUST-1:0] lane_b,
    output logic              dat_sel,
    output logic [NCLUST-1:0] win_oh,
    output logic              conflict
);

    logic [NCLUST-1:0] busy, pick_b;
    logic [CW-1:0]     nbusy;

    for (genvar c = 0; c < NCLUST; c++) begin : g_field
        assign busy[c]   = |dsel[2*c +: 2];
        assign pick_b[c] = dsel[2*c+1] && !dsel[2*c];
    end

    always_comb begin
        win_oh  = '0;
        dat_sel = 1'b0;
        nbusy   = '0;
        // walk downward so the lowest busy cluster is the one left standing
        for (int c = NCLUST - 1; c >= 0; c--) begin
            if (busy[c]) begin
                win_oh    = '0;
                win_oh[c] = 1'b1;
                dat_sel   = pick_b[c] ? lane_b[c] : lane_a[c];
                nbusy     = nbusy + CW'(1);
            end
        end
        conflict = nbusy > CW'(1);
    end

endmodule

// File: rtl/audio_port_xbar.sv
module audio_port_xbar
    import xbar_pkg::*;
#(
    parameter int NCLUST = 6,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic [NCLUST-1:0] clu_bclk,
    input  logic [NCLUST-1:0] clu_fsync,
    input  logic [NCLUST-1:0] clu_txa,
    input  logic [NCLUST-1:0] clu_txb,
    output logic              port_bclk,
    output logic              port_fsync,
    output logic              port_sdata,
    output logic              port_conflict
);

    localparam int DSW = 2 * NCLUST;

    port_en_t          en_act;
    logic [SEL_W-1:0]  csel_act;
    logic [DSW-1:0]    dsel_act;
    logic              src_valid, boundary;
    logic              bclk_sel, fs_sel, dat_sel, conflict_c;
    logic [NCLUST-1:0] win_oh;
    port_out_t         out_q;

    xbar_cfg_stage #(.NCLUST(NCLUST), .DW(DW)) cfg_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .src_valid(src_valid),
        .boundary (boundary),
        .en_q     (en_act),
        .csel_q   (csel_act),
        .dsel_q   (dsel_act)
    );

    xbar_clk_route #(.NCLUST(NCLUST)) clk_i (
        .clk      (clk),
        .rst      (rst),
        .csel     (csel_act),
        .bclk_in  (clu_bclk),
        .fsync_in (clu_fsync),
        .bclk_sel (bclk_sel),
        .fs_sel   (fs_sel),
        .src_valid(src_valid),
        .boundary (boundary)
    );

    xbar_lane_pick #(.NCLUST(NCLUST)) lane_i (
        .dsel    (dsel_act),
        .lane_a  (clu_txa),
        .lane_b  (clu_txb),
        .dat_sel (dat_sel),
        .win_oh  (win_oh),
        .conflict(conflict_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.bclk     <= en_act.bclk && bclk_sel;
            out_q.fs       <= en_act.fs && fs_sel;
            out_q.dat      <= en_act.dat && dat_sel;
            out_q.conflict <= conflict_c;
        end
    end

    assign port_bclk     = out_q.bclk;
    assign port_fsync    = out_q.fs;
    assign port_sdata    = out_q.dat;
    assign port_conflict = out_q.conflict;

endmodule

// File: rtl/audio_port_xbar_chk.sv
module audio_port_xbar_chk
    import xbar_pkg::*;
#(
    parameter int NCLUST = 6,
    parameter int DW     = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_we,
    input logic [1:0]          cfg_addr,
    input logic [DW-1:0]       cfg_wdata,
    input logic                port_bclk,
    input logic                port_fsync,
    input logic                port_sdata,
    input logic                port_conflict,
    input port_en_t            en_act,
    input logic [SEL_W-1:0]    csel_act,
    input logic [2*NCLUST-1:0] dsel_act,
    input logic                src_valid,
    input logic                boundary,
    input logic [NCLUST-1:0]   win_oh
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !port_bclk && !port_fsync && !port_sdata && !port_conflict);

    // R2
    bclk_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_addr == 2'd0 && !cfg_wdata[EN_BCLK_BIT] |=> ##1 !port_bclk);

    // R3
    fsync_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_addr == 2'd0 && !cfg_wdata[EN_FS_BIT] |=> ##1 !port_fsync);

    // R4
    data_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we && cfg_addr == 2'd0 && !cfg_wdata[EN_DAT_BIT] |=> ##1 !port_sdata);

    // R6
    single_winner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_oh));

    // R7
    empty_select_chk: assert property (@(posedge clk) disable iff (rst)
        dsel_act == '0 |=> !port_sdata && !port_conflict);

    // R8
    hold_clksel_chk: assert property (@(posedge clk) disable iff (rst)
        (en_act.bclk || en_act.fs) && src_valid && !boundary |=> $stable(csel_act));

    // R8
    hold_datsel_chk: assert property (@(posedge clk) disable iff (rst)
        en_act.dat && src_valid && !boundary |=> $stable(dsel_act));

endmodule

bind audio_port_xbar audio_port_xbar_chk #(.NCLUST(NCLUST), .DW(DW)) chk_i (.*);

// File: tb/audio_port_xbar_tb.sv
module audio_port_xbar_tb_top;

    localparam int NC = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [NC-1:0] clu_bclk = '0, clu_fsync = '0, clu_txa = '0, clu_txb = '0;
    logic          port_bclk, port_fsync, port_sdata, port_conflict;

    audio_port_xbar #(.NCLUST(NC), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .clu_bclk(clu_bclk), .clu_fsync(clu_fsync),
        .clu_txa(clu_txa), .clu_txb(clu_txb), .port_bclk(port_bclk),
        .port_fsync(port_fsync), .port_sdata(port_sdata),
        .port_conflict(port_conflict)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    string phase    = "R1";
    bit    done     = 0;

    // behavioural reference state
    bit [3:0]      m_en;
    int            m_csel_sh, m_csel;
    bit [2*NC-1:0] m_dsel_sh, m_dsel;
    bit            m_fsprev, m_bclk, m_fs, m_dat, m_conf;
    int            src, win, nbusy, f;
    bit            valid, fsm, bnd, app_c, app_d;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_csel_sh = 0; m_csel = 0; m_dsel_sh = 0; m_dsel = 0;
            m_fsprev = 0; m_bclk = 0; m_fs = 0; m_dat = 0; m_conf = 0;
        end else begin
            src   = m_csel;
            valid = (src >= 1) && (src <= NC);
            fsm   = valid ? clu_fsync[src-1] : 1'b0;
            bnd   = fsm && !m_fsprev;
            m_bclk = m_en[1] && valid && clu_bclk[src-1];
            m_fs   = m_en[2] && fsm;
            win = -1; nbusy = 0;
            for (int c = 0; c < NC; c++) begin
                if (m_dsel[2*c +: 2] != 0) begin
                    nbusy++;
                    if (win < 0) win = c;
                end
            end
            if (win >= 0) begin
                f = m_dsel[2*win +: 2];
                m_dat = m_en[3] && ((f == 2) ? clu_txb[win] : clu_txa[win]);
            end else begin
                m_dat = 0;
            end
            m_conf = nbusy > 1;
            app_c = (m_en[2:1] == 0) || !valid || bnd;
            app_d = !m_en[3] || !valid || bnd;
            m_fsprev = fsm;
            if (cfg_we && cfg_addr == 1) m_csel_sh = cfg_wdata[11:8];
            if (cfg_we && cfg_addr == 2) m_dsel_sh = cfg_wdata[2*NC-1:0];
            if (app_c) m_csel = m_csel_sh;
            if (app_d) m_dsel = m_dsel_sh;
            if (cfg_we && cfg_addr == 0) m_en = {cfg_wdata[3:1], 1'b0};
        end
    end

    task automatic check_bit(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (phase %s) cycle %0d: actual %b expected %b",
                     tag, phase, cyc, act, exp);
        end
    endtask

    task automatic drive_clusters();
        for (int c = 0; c < NC; c++) begin
            clu_bclk[c]  = ((cyc / (c + 1)) % 2) == 1;
            clu_fsync[c] = (cyc % (20 + 6 * c)) < 2;
            clu_txa[c]   = 1'($urandom);
            clu_txb[c]   = 1'($urandom);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check_bit("R2 bclk", port_bclk, m_bclk);
        check_bit("R3 fsync", port_fsync, m_fs);
        check_bit("R4 sdata", port_sdata, m_dat);
        check_bit("R6 conflict", port_conflict, m_conf);
        cyc++;
        cfg_we = 1'b0;
        drive_clusters();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(int a, int d);
        cfg_we    = 1'b1;
        cfg_addr  = 2'(a);
        cfg_wdata = DW'(d);
        tick();
    endtask

    task automatic expect_quiet(string tag);
        check_bit(tag, port_bclk | port_fsync | port_sdata | port_conflict, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        drive_clusters();
        run(3);
        phase = "R1";
        expect_quiet("R1 reset");
        rst = 1'b0;
        tick();
        expect_quiet("R1 after release");

        // R12: clocks from every cluster, R2 and R3 gating
        phase = "R12";
        wr(0, 'h6);
        for (int c = 0; c < NC; c++) begin
            wr(1, (c + 1) << 8);
            run(70);
        end
        phase = "R2";
        wr(0, 'h2);
        run(40);
        phase = "R3";
        wr(0, 'h4);
        run(40);

        // R4: lane A and lane B per cluster
        phase = "R4";
        wr(0, 'hE);
        for (int c = 0; c < NC; c++) begin
            wr(2, 1 << (2 * c));
            run(50);
            wr(2, 2 << (2 * c));
            run(50);
            wr(2, 3 << (2 * c));
            run(30);
        end

        // R6: several busy fields
        phase = "R6";
        wr(2, (2 << 6) | (1 << 2) | (2 << 10));
        run(60);
        wr(2, (1 << 8) | (2 << 10));
        run(60);

        // R7: nothing selected
        phase = "R7";
        wr(2, 0);
        run(60);
        check_bit("R7 sdata low", port_sdata, 1'b0);

        // R8: changes held while running
        phase = "R8";
        wr(2, 2 << 4);
        run(40);
        wr(1, 2 << 8);
        wr(2, 1);
        run(60);

        // R5: no source and out of range
        phase = "R5";
        wr(1, 0);
        run(60);
        check_bit("R5 bclk low", port_bclk, 1'b0);
        wr(1, 7 << 8);
        run(40);
        check_bit("R5 fsync low", port_fsync, 1'b0);

        // R9: idle outputs take selections at once
        phase = "R9";
        wr(0, 0);
        wr(1, 4 << 8);
        wr(2, 2 << 2);
        wr(0, 'hE);
        run(60);

        // R11: spare address ignored
        phase = "R11";
        wr(3, 'hFFFF);
        run(60);

        // R10: shutdown
        phase = "R10";
        wr(2, (1 << 0) | (1 << 4));
        run(30);
        wr(0, 0);
        wr(2, 0);
        run(10);
        expect_quiet("R10 shutdown");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (phase %s): actual hung expected finished", phase);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule